// File: doc/BRIEF.md
# Timer Interrupt Flag and Mask Unit

This unit collects single-cycle event pulses from two timer/counters and turns them into an interrupt request for a CPU. Four sources are tracked: two compare-match events and an overflow event from the wider timer 1, and an overflow event from timer 0. Each source has a sticky flag and an enable bit. The flags and enables are reached through a small register port. A source requests service only while the global interrupt enable, its enable bit and its flag are all one.

The request line and the vector number are both registered. When several sources are pending, the lowest vector number is presented. A flag can be cleared in two ways. Software can write a one to the flag bit, and this clear lands one cycle after the write. The CPU can also acknowledge the presented vector, which clears only that source's flag. A three-state controller sequences the request. `ST_IDLE` means no request. `ST_REQ` means the request is driven. `ST_SETTLE` is a one-cycle gap after an acknowledge, which lets the cleared flag take effect before the winner is chosen again. The transitions are:
- idle-to-request: any enabled source is pending.
- request-to-idle: the pending condition goes away.
- request-to-settle: an acknowledge arrives.
- settle-to-request: a source is still pending.
- settle-to-idle: nothing is pending.

Top module: `tmr_irq_unit`

## Requirements
- R1: After reset, both registers read zero, `irq_o` is 0 and `irq_vec_o` is 0.
- R2: `reg_sel_i` = 0 selects the enable register and 1 selects the flag register. In both registers, bit 6 is compare A, bit 5 is compare B, bit 2 is timer 1 overflow and bit 1 is timer 0 overflow. Bits 7, 4, 3 and 0 ignore writes and always read zero.
- R3: An event pulse sets its flag on the clock edge where the pulse is sampled. The flag reads one from the next cycle on, whether or not the source is enabled.
- R4: Writing the flag register clears each flag whose data bit is one. The flag still reads one after the write edge and reads zero after the following edge. Zero data bits leave flags unchanged.
- R5: If an event pulse meets a clear on the same edge, the flag stays set. This holds for a delayed software clear and for an acknowledge clear.
- R6: `irq_o` rises one cycle after global enable, enable bit and flag are all one for some source. It stays low when any of the three is zero.
- R7: While `irq_o` is 1, `irq_vec_o` shows the vector of the lowest pending enabled source. The vectors are compare A = 3, compare B = 4, timer 1 overflow = 5 and timer 0 overflow = 6. While `irq_o` is 0, `irq_vec_o` is 0.
- R8: `vec_ack_i` while `irq_o` is 1 has these effects. On that edge it clears only the presented source's flag. `irq_o` is 0 for the next cycle. The request is then re-evaluated.
- R9: `vec_ack_i` while `irq_o` is 0 has no effect on any flag.
- R10: Dropping the global enable while a request is driven lowers `irq_o` after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_a_evt_i | input | 1 | Timer 1 compare A event pulse |
| cmp_b_evt_i | input | 1 | Timer 1 compare B event pulse |
| t1_ovf_evt_i | input | 1 | Timer 1 overflow event pulse |
| t0_ovf_evt_i | input | 1 | Timer 0 overflow event pulse |
| gie_i | input | 1 | Global interrupt enable |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 enable, 1 flag |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Read data of selected register |
| vec_ack_i | input | 1 | Vector acknowledge from CPU |
| irq_o | output | 1 | Registered interrupt request |
| irq_vec_o | output | 3 | Vector of presented source, 0 when idle |

## Verification
The hardest cases to reach are the collisions of the set-wins rule. An event pulse must land exactly on the edge where a delayed write-one clear takes effect, one cycle after the write strobe. An event pulse must also land on the edge where an acknowledge clears the same source. The bench drives inputs at falling edges and counts edges from the write, so each pulse is placed on the edge it is meant for. The acknowledge sequence keeps two sources pending. This shows the one-cycle gap and the hand-over from vector 3 to vector 6.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
    localparam int NSRC  = 4;
    localparam int REG_W = 8;
    // register bit of each source; order of sources is priority order
    localparam int SRC_BIT [NSRC] = '{6, 5, 2, 1};
    localparam logic [REG_W-1:0] RSV_MASK = 8'h99;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_REQ    = 2'd1,
        ST_SETTLE = 2'd2
    } irq_state_t;
endpackage

// File: rtl/tmr_irq_regs.sv
module tmr_irq_regs
    import tmr_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  evt_i,
    input  logic [NSRC-1:0]  ack_clr_i,
    input  logic             we_i,
    input  logic             sel_i,
    input  logic [REG_W-1:0] wdata_i,
    output logic [REG_W-1:0] rdata_o,
    output logic [NSRC-1:0]  flag_o,
    output logic [NSRC-1:0]  mask_o
);
    logic [NSRC-1:0] flag_q, mask_q, clr_pend_q;
    logic [NSRC-1:0] clr_pend_d, flag_d, mask_d;
    logic            unused_rsv;

    assign unused_rsv = ^(wdata_i & RSV_MASK);

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        assign clr_pend_d[i] = we_i & sel_i & wdata_i[SRC_BIT[i]];
        assign mask_d[i]     = (we_i & ~sel_i) ? wdata_i[SRC_BIT[i]] : mask_q[i];
        // set has priority over both clear paths
        assign flag_d[i]     = evt_i[i] | (flag_q[i] & ~(clr_pend_q[i] | ack_clr_i[i]));

        p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
            evt_i[i] |=> flag_q[i]);
        p_clear_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_pend_q[i] && !evt_i[i]) |=> !flag_q[i]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q     <= '0;
            mask_q     <= '0;
            clr_pend_q <= '0;
        end else begin
            flag_q     <= flag_d;
            mask_q     <= mask_d;
            clr_pend_q <= clr_pend_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < NSRC; i++) begin
            rdata_o[SRC_BIT[i]] = sel_i ? flag_q[i] : mask_q[i];
        end
    end

    assign flag_o = flag_q;
    assign mask_o = mask_q;
endmodule

// File: rtl/tmr_irq_arb.sv
module tmr_irq_arb
    import tmr_irq_pkg::*;
#(
    parameter int IDX_W = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]  pend_i,
    output logic             any_o,
    output logic [IDX_W-1:0] win_idx_o,
    output logic [NSRC-1:0]  win_oh_o
);
    assign any_o = |pend_i;

    for (genvar i = 0; i < NSRC; i++) begin : g_oh
        if (i == 0) begin : g_first
            assign win_oh_o[i] = pend_i[i];
        end else begin : g_rest
            assign win_oh_o[i] = pend_i[i] & ~(|pend_i[i-1:0]);
        end
    end

    always_comb begin
        win_idx_o = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pend_i[i]) win_idx_o = IDX_W'(i);
        end
    end
endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl
    import tmr_irq_pkg::*;
#(
    parameter int VEC_BASE = 3,
    parameter int VEC_W    = 3,
    parameter int IDX_W    = $clog2(NSRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             any_i,
    input  logic [IDX_W-1:0] win_idx_i,
    input  logic [NSRC-1:0]  win_oh_i,
    input  logic             ack_i,
    output logic             irq_o,
    output logic [VEC_W-1:0] vec_o,
    output logic [NSRC-1:0]  ack_clr_o
);
    irq_state_t      state_q, state_d;
    logic [NSRC-1:0] oh_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = any_i ? ST_REQ : ST_IDLE;
            ST_REQ:    state_d = ack_i ? ST_SETTLE : (any_i ? ST_REQ : ST_IDLE);
            ST_SETTLE: state_d = any_i ? ST_REQ : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_o <= '0;
            oh_q  <= '0;
        end else if (state_d == ST_REQ) begin
            vec_o <= VEC_W'(VEC_BASE) + VEC_W'(win_idx_i);
            oh_q  <= win_oh_i;
        end else begin
            vec_o <= '0;
            oh_q  <= '0;
        end
    end

    assign irq_o     = (state_q == ST_REQ);
    assign ack_clr_o = (ack_i && state_q == ST_REQ) ? oh_q : '0;

    p_ack_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && ack_i) |=> !irq_o);
    p_vec_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> (vec_o == '0));
    p_vec_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (vec_o >= VEC_W'(VEC_BASE) && vec_o <= VEC_W'(VEC_BASE + NSRC - 1)));
    p_ack_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> (ack_clr_o == '0));
endmodule

// File: rtl/tmr_irq_unit.sv
module tmr_irq_unit
    import tmr_irq_pkg::*;
#(
    parameter int VEC_BASE = 3,
    parameter int VEC_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_a_evt_i,
    input  logic             cmp_b_evt_i,
    input  logic             t1_ovf_evt_i,
    input  logic             t0_ovf_evt_i,
    input  logic             gie_i,
    input  logic             reg_we_i,
    input  logic             reg_sel_i,
    input  logic [7:0]       reg_wdata_i,
    output logic [7:0]       reg_rdata_o,
    input  logic             vec_ack_i,
    output logic             irq_o,
    output logic [VEC_W-1:0] irq_vec_o
);
    localparam int IDX_W = $clog2(NSRC);

    logic [NSRC-1:0]  evt, flag, mask, pend, win_oh, ack_clr;
    logic [IDX_W-1:0] win_idx;
    logic             any_req;

    assign evt  = {t0_ovf_evt_i, t1_ovf_evt_i, cmp_b_evt_i, cmp_a_evt_i};
    assign pend = flag & mask & {NSRC{gie_i}};

    tmr_irq_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt),
        .ack_clr_i (ack_clr),
        .we_i      (reg_we_i),
        .sel_i     (reg_sel_i),
        .wdata_i   (reg_wdata_i),
        .rdata_o   (reg_rdata_o),
        .flag_o    (flag),
        .mask_o    (mask)
    );

    tmr_irq_arb #(.IDX_W(IDX_W)) u_arb (
        .pend_i    (pend),
        .any_o     (any_req),
        .win_idx_o (win_idx),
        .win_oh_o  (win_oh)
    );

    tmr_irq_ctrl #(.VEC_BASE(VEC_BASE), .VEC_W(VEC_W), .IDX_W(IDX_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .any_i     (any_req),
        .win_idx_i (win_idx),
        .win_oh_i  (win_oh),
        .ack_i     (vec_ack_i),
        .irq_o     (irq_o),
        .vec_o     (irq_vec_o),
        .ack_clr_o (ack_clr)
    );

    p_rsv_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata_o & RSV_MASK) == '0);
    p_irq_needs_gie_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(gie_i));
    p_gie_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !gie_i |=> !irq_o);
endmodule

// File: tb/tmr_irq_unit_tb_top.sv
`timescale 1ns/1ps
module tmr_irq_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] evt = '0;   // [0] cmp A, [1] cmp B, [2] t1 ovf, [3] t0 ovf
    logic       gie = 1'b0, we = 1'b0, sel = 1'b0, ack = 1'b0;
    logic [7:0] wdata = '0, rdata;
    logic       irq;
    logic [2:0] vec;
    int         total = 0, fails = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    tmr_irq_unit dut_i (
        .clk(clk), .rst_n(rst_n),
        .cmp_a_evt_i(evt[0]), .cmp_b_evt_i(evt[1]),
        .t1_ovf_evt_i(evt[2]), .t0_ovf_evt_i(evt[3]),
        .gie_i(gie), .reg_we_i(we), .reg_sel_i(sel), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .vec_ack_i(ack), .irq_o(irq), .irq_vec_o(vec)
    );

    // row: {mask[7:0], evt[3:0], gie, exp_irq, exp_vec[2:0]}
    localparam logic [16:0] TBL [10] = '{
        {8'h66, 4'b1111, 1'b1, 1'b1, 3'd3},
        {8'h66, 4'b1110, 1'b1, 1'b1, 3'd4},
        {8'h66, 4'b1100, 1'b1, 1'b1, 3'd5},
        {8'h66, 4'b1000, 1'b1, 1'b1, 3'd6},
        {8'h02, 4'b1111, 1'b1, 1'b1, 3'd6},
        {8'h66, 4'b1111, 1'b0, 1'b0, 3'd0},
        {8'h00, 4'b1111, 1'b1, 1'b0, 3'd0},
        {8'h99, 4'b1111, 1'b1, 1'b0, 3'd0},
        {8'h24, 4'b0101, 1'b1, 1'b1, 3'd5},
        {8'h66, 4'b0000, 1'b1, 1'b0, 3'd0}
    };

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic s, input logic [7:0] d);
        we = 1'b1; sel = s; wdata = d;
        step();
        we = 1'b0; wdata = '0;
    endtask

    task automatic pulse(input logic [3:0] e);
        evt = e;
        step();
        evt = '0;
    endtask

    task automatic rd(input string tag, input logic s, input logic [7:0] exp);
        sel = s;
        #0.1;
        chk(tag, rdata, exp);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        step(); step(); step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk("R1 irq", {7'd0, irq}, 8'h00);
        chk("R1 vec", {5'd0, vec}, 8'h00);
        rd("R1 mask", 1'b0, 8'h00);
        rd("R1 flag", 1'b1, 8'h00);

        // table: R6 gating and R7 priority
        for (int r = 0; r < 10; r++) begin
            wr(1'b0, TBL[r][16:9]);
            gie = TBL[r][4];
            pulse(TBL[r][8:5]);
            step();
            chk($sformatf("R6 row%0d irq", r), {7'd0, irq}, {7'd0, TBL[r][3]});
            chk($sformatf("R7 row%0d vec", r), {5'd0, vec}, {5'd0, TBL[r][2:0]});
            gie = 1'b0;
            wr(1'b1, 8'hFF);
            step();
        end

        // R2 enable register bit map
        wr(1'b0, 8'hFF);
        rd("R2 mask", 1'b0, 8'h66);
        // R3 / R2 flag set and bit map
        pulse(4'b1111);
        rd("R3 flag", 1'b1, 8'h66);
        // R4 delayed write-one clear
        wr(1'b1, 8'h40);
        rd("R4 not yet", 1'b1, 8'h66);
        step();
        rd("R4 cleared", 1'b1, 8'h26);
        wr(1'b1, 8'h00);
        step();
        rd("R4 zero write", 1'b1, 8'h26);
        // R5 event on the edge the clear lands
        wr(1'b1, 8'h20);
        pulse(4'b0010);
        rd("R5 set wins sw", 1'b1, 8'h26);
        step();
        rd("R5 still set", 1'b1, 8'h26);
        wr(1'b1, 8'hFF);
        step();
        rd("R4 all clear", 1'b1, 8'h00);

        // R8 acknowledge sequence
        wr(1'b0, 8'h66);
        gie = 1'b1;
        pulse(4'b1001);
        step();
        chk("R8 irq", {7'd0, irq}, 8'h01);
        chk("R8 vec a", {5'd0, vec}, 8'h03);
        ack = 1'b1; step(); ack = 1'b0;
        chk("R8 gap irq", {7'd0, irq}, 8'h00);
        chk("R8 gap vec", {5'd0, vec}, 8'h00);
        rd("R8 only winner", 1'b1, 8'h02);
        step();
        chk("R8 next irq", {7'd0, irq}, 8'h01);
        chk("R8 next vec", {5'd0, vec}, 8'h06);
        ack = 1'b1; step(); ack = 1'b0;
        rd("R8 flags empty", 1'b1, 8'h00);
        step();
        chk("R8 idle", {7'd0, irq}, 8'h00);

        // R5 event colliding with acknowledge
        pulse(4'b0001);
        step();
        chk("R5 pre vec", {5'd0, vec}, 8'h03);
        ack = 1'b1; evt = 4'b0001; step(); ack = 1'b0; evt = '0;
        rd("R5 set wins ack", 1'b1, 8'h40);
        chk("R5 gap", {7'd0, irq}, 8'h00);
        step();
        chk("R5 re-request", {5'd0, vec}, 8'h03);
        // R10 global enable drop
        gie = 1'b0;
        step();
        chk("R10 irq low", {7'd0, irq}, 8'h00);
        wr(1'b1, 8'hFF);
        step();

        // R9 acknowledge ignored while idle
        pulse(4'b0001);
        ack = 1'b1; step(); ack = 1'b0;
        rd("R9 flag kept", 1'b1, 8'h40);
        gie = 1'b1;
        #0.1;
        chk("R6 before edge", {7'd0, irq}, 8'h00);
        step();
        chk("R6 one cycle", {7'd0, irq}, 8'h01);
        chk("R7 vec", {5'd0, vec}, 8'h03);
        // R6 enable bit removed
        wr(1'b0, 8'h00);
        step();
        chk("R6 mask off", {7'd0, irq}, 8'h00);

        finish_run();
    end
endmodule